// File: doc/BRIEF.md
# I2C Target Configuration Register Bank

This block is a two-wire serial target that lets a host read and write a bank of sixteen 8-bit configuration registers. Every register is also presented in parallel on a flat output bus, so downstream logic sees a new value as soon as the host has written it. The serial lines are sampled by the block's own fast clock: SCL and SDA each pass through a synchronizer, START and STOP are found as SDA edges while SCL is high, and the block pulls SDA low only through an active-low output enable. An open-drain pad or a wired-AND on the board provides the bus.

A transaction begins with START and a 7-bit address. The address is 1011X00, where X follows a strap input, so two of these blocks can share one bus. In a write, the first byte after the address loads a 4-bit register pointer. Each later byte is stored at the pointer, and the pointer then advances modulo 16. To read, the host sets the pointer, issues a repeated START, and sends the address with the read bit set. The block then returns bytes from the pointer onward until the host answers with NACK.

Top module: `cfg_i2c_bank`

## Requirements
- R1: After reset all sixteen registers read zero on `regs_o` and `sda_oe_n_o` is high (SDA released).
- R2: Only the address byte {1011, addr_strap_i, 00, R/W} (address bits 7..1, R/W in bit 0) is acknowledged. Any other address is not acknowledged, and the rest of that transaction leaves the registers unchanged.
- R3: The general call address (seven zero bits) is not acknowledged.
- R4: In a write, the low 4 bits of the first byte after the address set the register pointer. Each following byte is stored in the register the pointer selects, where register n occupies `regs_o[8n+7:8n]`.
- R5: The pointer advances by one after every byte written or read, and it wraps from register 15 to register 0.
- R6: A written register takes its new value when the block acknowledges that byte, before any STOP.
- R7: A byte cut short by STOP or by a repeated START is discarded and changes no register.
- R8: A pointer write, a repeated START and the address with R/W = 1 make the block send registers MSB first, from the pointer onward, for as long as the host acknowledges each byte.
- R9: After the host answers a read byte with NACK, SDA is released (`sda_oe_n_o` high) until the next START or STOP.
- R10: `sda_oe_n_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| addr_strap_i | input | 1 | Selects bit 2 of the target address |
| sda_oe_n_o | output | 1 | Low pulls SDA low; high releases SDA |
| regs_o | output | 128 | All registers, register n at bits 8n+7..8n |

## Verification
Directed transactions check each boundary. Writes that start at register 14 and cross the wrap show the modulo-16 pointer. A read sequence that begins at 15 shows the same wrap on the read path. Bytes cut off by STOP or by a repeated START are checked separately from complete ones. A wrong address, the general call address and the two strap settings show that the address match depends on the strap bit. Constrained random writes of random length at random pointers, followed by a full 16-byte sequential read from a random start, catch errors in pointer arithmetic and byte ordering that the fixed patterns could miss. The parallel outputs are checked just after the data ACK and before STOP, which separates commit at acknowledge from commit at STOP.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } ph_e;
endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;
  logic              scl_s, sda_s;

  // synchronizer chain, reset to idle-bus level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  always_comb begin
    scl_s      = scl_ff[STAGES-1];
    sda_s      = sda_ff[STAGES-1];
    sda_o      = sda_s;
    scl_rise_o = scl_s & ~scl_d;
    scl_fall_o = ~scl_s & scl_d;
    start_o    = scl_s & scl_d & sda_d & ~sda_s;
    stop_o     = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs #(
  parameter int NUM = 16,
  parameter int DW  = 8,
  localparam int AW = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic [NUM*DW-1:0] regs_flat
);
  logic [DW-1:0] mem [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (hit) begin
        mem[g] <= wr_data;
      end
    end
    assign regs_flat[g*DW +: DW] = mem[g];
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM       = 16,
  parameter int         DW        = 8,
  parameter logic [6:0] DEV_ADDR  = 7'b1011000,
  parameter int         STRAP_BIT = 2,
  localparam int        AW        = $clog2(NUM),
  localparam int        CW        = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start,
  input  logic          stop,
  input  logic          sda_s,
  input  logic          strap,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe_n,
  output logic          wait_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  st_e           st_q, st_d;
  ph_e           ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          nack_q, nack_d;
  logic          oe_q, oe_d;
  logic [6:0]    dev;

  always_comb begin
    dev            = DEV_ADDR;
    dev[STRAP_BIT] = strap;
  end

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    nack_d = nack_q;
    oe_d   = oe_q;
    wr_en  = 1'b0;
    if (start) begin
      st_d  = ST_RX;
      ph_d  = PH_ADDR;
      cnt_d = '0;
      oe_d  = 1'b1;
    end else if (stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == dev) begin
                  rw_d = sh_q[0];
                  st_d = ST_ACK;
                  oe_d = 1'b0;
                end else begin
                  st_d = ST_WAIT;
                end
              end
              PH_PTR: begin
                ptr_d = sh_q[AW-1:0];
                st_d  = ST_ACK;
                oe_d  = 1'b0;
              end
              default: begin
                wr_en = 1'b1;
                ptr_d = ptr_q + 1'b1;
                st_d  = ST_ACK;
                oe_d  = 1'b0;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (ph_q == PH_ADDR && rw_q) begin
              st_d  = ST_TX;
              sh_d  = rd_data;
              ptr_d = ptr_q + 1'b1;
              oe_d  = rd_data[DW-1];
            end else begin
              st_d = ST_RX;
              oe_d = 1'b1;
              ph_d = (ph_q == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_d = ST_MACK;
              oe_d = 1'b1;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              oe_d  = sh_q[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_WAIT;
            end else begin
              st_d  = ST_TX;
              sh_d  = rd_data;
              ptr_d = ptr_q + 1'b1;
              cnt_d = '0;
              oe_d  = rd_data[DW-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      nack_q <= nack_d;
      oe_q   <= oe_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign wr_data  = sh_q;
  assign sda_oe_n = oe_q;
  assign wait_o   = (st_q == ST_WAIT);
endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank #(
  parameter int NUM         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_oe_n_o,
  output logic [NUM*DW-1:0] regs_o
);
  localparam int AW = $clog2(NUM);

  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic          wr_en, fsm_wait;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] wr_data, rd_data;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync[1];

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  cfg_i2c_fsm #(.NUM(NUM), .DW(DW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start   (start),
    .stop    (stop),
    .sda_s   (sda_s),
    .strap   (addr_strap_i),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .ptr_o   (ptr_q),
    .wr_data (wr_data),
    .sda_oe_n(sda_oe_n_o),
    .wait_o  (fsm_wait)
  );

  cfg_i2c_regs #(.NUM(NUM), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_idx   (ptr_q),
    .wr_data  (wr_data),
    .rd_idx   (ptr_q),
    .rd_data  (rd_data),
    .regs_flat(regs_o)
  );
endmodule

// File: rtl/cfg_i2c_bank_chk.sv
module cfg_i2c_bank_chk #(
  parameter int NUM = 16,
  parameter int DW  = 8,
  localparam int AW = $clog2(NUM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_n_o,
  input logic [NUM*DW-1:0] regs_o,
  input logic              wr_en,
  input logic [AW-1:0]     ptr_q,
  input logic              fsm_wait
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (regs_o == '0 && sda_oe_n_o));

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_n_o) |-> !scl_i);

  // R6
  reg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(wr_en));

  // R5
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == AW'($past(ptr_q) + 1'b1));

  // R9
  released_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_wait |-> sda_oe_n_o);
endmodule

bind cfg_i2c_bank cfg_i2c_bank_chk #(.NUM(NUM), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .scl_i     (scl_i),
  .sda_oe_n_o(sda_oe_n_o),
  .regs_o    (regs_o),
  .wr_en     (wr_en),
  .ptr_q     (ptr_q),
  .fsm_wait  (fsm_wait)
);

// File: tb/cfg_i2c_bank_tb.sv
module cfg_i2c_bank_tb_top;
  localparam int Q = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl_m = 1'b1;
  logic         sda_m = 1'b1;
  logic         strap = 1'b1;
  logic         sda_oe_n;
  logic [127:0] regs;
  logic         sda_line;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [16];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;
  assign sda_line = sda_m & sda_oe_n;

  cfg_i2c_bank dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_strap_i(strap),
    .sda_oe_n_o  (sda_oe_n),
    .regs_o      (regs)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] dev_byte(input logic s, input logic rw);
    return {4'b1011, s, 2'b00, rw};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!give_ack);
  endtask

  // full write: pointer p then n bytes from wbuf
  task automatic do_write(input logic [3:0] p, input int n);
    logic ack;
    bus_start();
    wr_byte(dev_byte(strap, 1'b0), ack);
    check(ack, "R2 address ack", {127'd0, ack}, 128'd1);
    wr_byte({4'h0, p}, ack);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      model[4'(p + i)] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [3:0] p, input int n);
    logic ack;
    bus_start();
    wr_byte(dev_byte(strap, 1'b0), ack);
    wr_byte({4'h0, p}, ack);
    bus_start();
    wr_byte(dev_byte(strap, 1'b1), ack);
    check(ack, "R8 read address ack", {127'd0, ack}, 128'd1);
    for (int i = 0; i < n; i++) rd_byte(i < n - 1, rbuf[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check(regs == '0, "R1 regs after reset", regs, '0);
    check(sda_oe_n == 1'b1, "R1 sda released", {127'd0, sda_oe_n}, 128'd1);

    // R4 R6 single write, checked before STOP
    bus_start();
    wr_byte(dev_byte(1'b1, 1'b0), ack);
    check(ack, "R2 strap=1 address ack", {127'd0, ack}, 128'd1);
    wr_byte(8'h05, ack);
    wr_byte(8'hA7, ack);
    check(regs[5*8 +: 8] == 8'hA7, "R6 commit at ack before STOP", regs[5*8 +: 8], 8'hA7);
    bus_stop();
    model[5] = 8'hA7;
    check(regs == model_flat(), "R4 write to pointed register", regs, model_flat());

    // R5 sequential write across the wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(4'd14, 4);
    check(regs == model_flat(), "R5 write wrap 14..1", regs, model_flat());

    // R7 partial byte then STOP
    bus_start();
    wr_byte(dev_byte(1'b1, 1'b0), ack);
    wr_byte(8'h03, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_stop();
    check(regs == model_flat(), "R7 partial byte on STOP", regs, model_flat());

    // R7 partial byte then repeated START, full transaction afterwards
    bus_start();
    wr_byte(dev_byte(1'b1, 1'b0), ack);
    wr_byte(8'h03, ack);
    for (int i = 0; i < 7; i++) put_bit(1'b0);
    bus_start();
    wr_byte(dev_byte(1'b1, 1'b0), ack);
    check(ack, "R7 address ack after repeated START", {127'd0, ack}, 128'd1);
    wr_byte(8'h09, ack);
    wr_byte(8'h5C, ack);
    bus_stop();
    model[9] = 8'h5C;
    check(regs == model_flat(), "R7 partial byte on repeated START", regs, model_flat());

    // R2 wrong strap value and other address, no writes
    bus_start();
    wr_byte(dev_byte(1'b0, 1'b0), ack);
    check(!ack, "R2 strap mismatch nack", {127'd0, ack}, 128'd0);
    wr_byte(8'h00, ack);
    wr_byte(8'hFF, ack);
    bus_stop();
    check(regs == model_flat(), "R2 ignored transaction", regs, model_flat());

    // R3 general call
    bus_start();
    wr_byte(8'h00, ack);
    check(!ack, "R3 general call nack", {127'd0, ack}, 128'd0);
    wr_byte(8'h02, ack);
    wr_byte(8'hEE, ack);
    bus_stop();
    check(regs == model_flat(), "R3 general call ignored", regs, model_flat());

    // R2 strap = 0 selects the other address
    strap = 1'b0;
    tick(Q);
    bus_start();
    wr_byte(dev_byte(1'b1, 1'b0), ack);
    check(!ack, "R2 old address nack after strap change", {127'd0, ack}, 128'd0);
    bus_stop();
    wbuf[0] = 8'h6B;
    do_write(4'd0, 1);
    check(regs == model_flat(), "R2 strap=0 write", regs, model_flat());

    // R8 R9 sequential read across the wrap from 15
    do_read(4'd15, 3);
    check(sda_oe_n == 1'b1, "R9 SDA released after NACK", {127'd0, sda_oe_n}, 128'd1);
    bus_stop();
    check(rbuf[0] == model[15], "R8 read reg15", rbuf[0], model[15]);
    check(rbuf[1] == model[0], "R5 read wrap reg0", rbuf[1], model[0]);
    check(rbuf[2] == model[1], "R8 read reg1", rbuf[2], model[1]);

    // random writes against the model
    for (int t = 0; t < 20; t++) begin
      logic [3:0] p;
      int n;
      p = 4'($urandom % 16);
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(p, n);
      check(regs == model_flat(), "R4 random write", regs, model_flat());
    end

    // full random-start sequential read of all sixteen
    begin
      logic [3:0] s;
      s = 4'($urandom % 16);
      do_read(s, 16);
      bus_stop();
      for (int i = 0; i < 16; i++)
        check(rbuf[i] == model[4'(s + i)], "R8 sequential read", rbuf[i], model[4'(s + i)]);
    end

    // R8 single random read
    do_read(4'd5, 1);
    b = rbuf[0];
    bus_stop();
    check(b == model[5], "R8 random read reg5", b, model[5]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule